// File: doc/BRIEF.md
# Line-Buffering Pixel Gap Remover

This block sits in a streaming video path and removes the holes that a bursty or rate-limited source leaves between the active pixels of a line. Each incoming pixel travels with a start-of-line, end-of-line, start-of-frame and end-of-frame flag and a valid strobe. Every valid pixel is written into a line buffer together with its four position flags. Pixel data and flags sit in separate RAMs, and both RAMs are addressed by the same write and read pointers.

A line becomes eligible for replay once its end-of-line pixel has been written. On the first input cycle that carries no valid pixel after that point, a read controller starts streaming the stored line out at one entry per cycle. The replay does not stop until the line's last entry has been sent. The output for a line is therefore one unbroken run from its start-of-line pixel to its end-of-line pixel. Each valid input produces exactly one valid output, so the number of active pixels per line and per frame is unchanged. Only the spacing of the pixels inside the blanking-padded line changes.

The buffer depth is a power of two. A non-power-of-two request is rounded up. The pixel may be a vector of `VEC` elements that share one valid strobe. In vector mode the start flags refer to element 0 and the end flags refer to the highest element, and the depth should cover the active pixels per line divided by `VEC`, plus 2. If a write arrives with nowhere to go, the pixel is discarded and a sticky overflow flag is raised.

Top module: `line_gap_remover`

## Requirements
- R1: After reset, `out_valid`, all four output flags, `out_pix` and `overflow` are 0.
- R2: Only input cycles with `in_valid` high are stored. Each stored entry appears exactly once at the output with the same pixel vector and the same flags, in input order. A line written without drops therefore yields as many valid outputs as it had valid inputs.
- R3: A stored line is replayed only after its `in_he` pixel has been written. Replay is issued on the first cycle after that write in which `in_valid` is low and no other line is replaying. The first replayed entry appears on the outputs 2 cycles after that issuing cycle, and one entry follows on each later cycle.
- R4: On the output, `out_valid` stays high on every cycle from a line's `out_hs` entry up to and including its `out_he` entry.
- R5: On any cycle with `out_valid` low, `out_pix` and all four output flags are 0.
- R6: The line buffer holds 2**ceil(log2(`DEPTH_REQ`)) entries. With `DEPTH_REQ`=48, a 64-entry contiguous line is stored and replayed without overflow.
- R7: A valid input that arrives while the buffer holds 2**ceil(log2(`DEPTH_REQ`)) unsent entries is discarded. The same cycle sets `overflow`, which then stays 1 until reset.
- R8: At most `LINES` completed lines can wait for replay. A valid `in_he` pixel that arrives when `LINES` lines are already waiting is discarded and sets `overflow`.
- R9: Element k of the pixel vector occupies bits [k*`PIX_W` +: `PIX_W`] of both `in_pix` and `out_pix`. All elements are carried through under the single valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_pix | input | VEC*PIX_W | Input pixel vector, element 0 in the low bits |
| in_hs | input | 1 | First pixel of a line |
| in_he | input | 1 | Last pixel of a line |
| in_vs | input | 1 | First pixel of a frame |
| in_ve | input | 1 | Last pixel of a frame |
| in_valid | input | 1 | Input pixel and flags are valid |
| out_pix | output | VEC*PIX_W | Output pixel vector |
| out_hs | output | 1 | First pixel of an output line |
| out_he | output | 1 | Last pixel of an output line |
| out_vs | output | 1 | First pixel of an output frame |
| out_ve | output | 1 | Last pixel of an output frame |
| out_valid | output | 1 | Output pixel and flags are valid |
| overflow | output | 1 | Sticky: a valid input was discarded |

## Verification
Two operations can land in the same cycle: a replay read issued from the buffer and a write of a new pixel from the next line, both of which update the occupancy count. The bench provokes this by leaving only a few idle cycles between lines. The replay of one line then starts on the first idle cycle and continues while the next line, fed in bursts or at every second cycle, is already being written. A behavioural model built on queues predicts the pixel, flags, valid and overflow for every cycle. The bench compares them against the outputs on every clock, so any lost, duplicated or reordered entry across this overlap is reported.

// File: rtl/lgr_pkg.sv
package lgr_pkg;
  typedef struct packed {
    logic hs;
    logic he;
    logic vs;
    logic ve;
  } lgr_flags_t;
  localparam int FLAG_W = 4;
endpackage

// File: rtl/lgr_ram.sv
module lgr_ram #(
  parameter int W  = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int N = 1 << AW;
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lgr_len_fifo.sv
module lgr_len_fifo #(
  parameter int CW    = 7,
  parameter int LINES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [CW-1:0] din,
  input  logic          pop,
  output logic [CW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int PW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int NW = $clog2(LINES + 1);

  logic [CW-1:0] slot [LINES];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == NW'(LINES));
  assign dout  = slot[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(LINES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        slot[wp] <= din;
        wp       <= nxt(wp);
      end
      if (pop) rp <= nxt(rp);
      cnt <= cnt + NW'(push) - NW'(pop);
    end
  end

  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);
  assert_no_pop_empty_R3: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
endmodule

// File: rtl/lgr_write_ctl.sv
module lgr_write_ctl #(
  parameter int AW = 6,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_hs,
  input  logic          in_he,
  input  logic          buf_full,
  input  logic          len_full,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          len_push,
  output logic [CW-1:0] len_val,
  output logic          overflow
);
  logic [AW-1:0] wptr;
  logic [CW-1:0] run_cnt;
  logic          accept, drop;

  assign accept   = in_valid && !buf_full && !(in_he && len_full);
  assign drop     = in_valid && !accept;
  assign we       = accept;
  assign waddr    = wptr;
  assign len_val  = (in_hs ? '0 : run_cnt) + 1'b1;
  assign len_push = accept && in_he;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      run_cnt  <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) begin
        wptr    <= wptr + 1'b1;
        run_cnt <= in_he ? '0 : len_val;
      end
      if (drop) overflow <= 1'b1;
    end
  end

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && buf_full) |=> overflow);
endmodule

// File: rtl/lgr_read_ctl.sv
module lgr_read_ctl #(
  parameter int AW = 6,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          len_empty,
  input  logic [CW-1:0] len_dout,
  output logic          len_pop,
  output logic          re,
  output logic [AW-1:0] raddr
);
  logic          busy;
  logic [CW-1:0] remain;
  logic          start;

  assign start   = !busy && !len_empty && !in_valid;
  assign len_pop = start;
  assign re      = start || busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
      raddr  <= '0;
    end else begin
      if (re) raddr <= raddr + 1'b1;
      if (start) begin
        remain <= len_dout - 1'b1;
        busy   <= (len_dout != CW'(1));
      end else if (busy) begin
        remain <= remain - 1'b1;
        if (remain == CW'(1)) busy <= 1'b0;
      end
    end
  end

  assert_busy_has_work_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (remain != '0));
endmodule

// File: rtl/line_gap_remover.sv
module line_gap_remover #(
  parameter int PIX_W     = 8,
  parameter int VEC       = 1,
  parameter int DEPTH_REQ = 256,
  parameter int LINES     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [VEC*PIX_W-1:0] in_pix,
  input  logic                 in_hs,
  input  logic                 in_he,
  input  logic                 in_vs,
  input  logic                 in_ve,
  input  logic                 in_valid,
  output logic [VEC*PIX_W-1:0] out_pix,
  output logic                 out_hs,
  output logic                 out_he,
  output logic                 out_vs,
  output logic                 out_ve,
  output logic                 out_valid,
  output logic                 overflow
);
  import lgr_pkg::*;

  localparam int AW    = (DEPTH_REQ > 1) ? $clog2(DEPTH_REQ) : 1;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;

  logic          we, re, len_push, len_pop, len_empty, len_full;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] len_val, len_dout;
  logic [CW-1:0] occ;
  logic          buf_full;
  logic          rd_vld;
  logic [VEC*PIX_W-1:0] q_pix;
  lgr_flags_t    w_flags, q_flags;

  assign buf_full = (occ == CW'(DEPTH));
  assign w_flags  = '{hs: in_hs, he: in_he, vs: in_vs, ve: in_ve};

  lgr_write_ctl #(.AW(AW), .CW(CW)) u_wr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hs(in_hs), .in_he(in_he),
    .buf_full(buf_full), .len_full(len_full), .we(we), .waddr(waddr),
    .len_push(len_push), .len_val(len_val), .overflow(overflow)
  );

  lgr_len_fifo #(.CW(CW), .LINES(LINES)) u_len (
    .clk(clk), .rst(rst), .push(len_push), .din(len_val), .pop(len_pop),
    .dout(len_dout), .empty(len_empty), .full(len_full)
  );

  lgr_read_ctl #(.AW(AW), .CW(CW)) u_rd (
    .clk(clk), .rst(rst), .in_valid(in_valid), .len_empty(len_empty),
    .len_dout(len_dout), .len_pop(len_pop), .re(re), .raddr(raddr)
  );

  generate
    for (genvar g = 0; g < VEC; g++) begin : g_pix_ram
      lgr_ram #(.W(PIX_W), .AW(AW)) u_pram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(in_pix[g*PIX_W +: PIX_W]),
        .re(re), .raddr(raddr), .rdata(q_pix[g*PIX_W +: PIX_W])
      );
    end
  endgenerate

  lgr_ram #(.W(FLAG_W), .AW(AW)) u_fram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(w_flags),
    .re(re), .raddr(raddr), .rdata(q_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      occ    <= '0;
      rd_vld <= 1'b0;
    end else begin
      occ    <= occ + CW'(we) - CW'(re);
      rd_vld <= re;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_vld) begin
      out_pix   <= '0;
      out_hs    <= 1'b0;
      out_he    <= 1'b0;
      out_vs    <= 1'b0;
      out_ve    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_pix   <= q_pix;
      out_hs    <= q_flags.hs;
      out_he    <= q_flags.he;
      out_vs    <= q_flags.vs;
      out_ve    <= q_flags.ve;
      out_valid <= 1'b1;
    end
  end

  assert_read_has_data_R3: assert property (@(posedge clk) disable iff (rst)
    re |-> (occ != '0));
  assert_occ_bound_R6: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));
  assert_line_gapfree_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_he) |=> out_valid);
  assert_idle_clear_R5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_pix == '0 && !out_hs && !out_he && !out_vs && !out_ve));
  assert_out_follows_read_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(rd_vld));
endmodule

// File: tb/sim_line_gap_remover.sv
module sim_line_gap_remover;
  localparam int PIX_W = 8, VEC = 2, DEPTH_REQ = 48, LINES = 2;
  localparam int DEPTH = 64;
  localparam int PW = VEC * PIX_W;

  logic clk = 0, rst = 1;
  logic [PW-1:0] in_pix = '0;
  logic in_hs = 0, in_he = 0, in_vs = 0, in_ve = 0, in_valid = 0;
  logic [PW-1:0] out_pix;
  logic out_hs, out_he, out_vs, out_ve, out_valid, overflow;

  int tests = 0, fails = 0, cycles = 0;
  int in_cnt = 0, out_cnt = 0;
  logic [PW-1:0] pix_seq = '0;

  always #2 clk = ~clk;

  line_gap_remover #(.PIX_W(PIX_W), .VEC(VEC), .DEPTH_REQ(DEPTH_REQ), .LINES(LINES)) u0 (
    .clk(clk), .rst(rst), .in_pix(in_pix), .in_hs(in_hs), .in_he(in_he),
    .in_vs(in_vs), .in_ve(in_ve), .in_valid(in_valid), .out_pix(out_pix),
    .out_hs(out_hs), .out_he(out_he), .out_vs(out_vs), .out_ve(out_ve),
    .out_valid(out_valid), .overflow(overflow)
  );

  // behavioural reference: queues of entries and line lengths
  logic [PW+3:0] dq[$];
  int lq[$];
  int m_busy, m_rem, m_run;
  logic [PW+3:0] e1, eo;
  bit e1v, eov, m_ovf;

  always @(posedge clk) begin
    if (rst) begin
      dq.delete(); lq.delete();
      m_busy = 0; m_rem = 0; m_run = 0;
      e1 = '0; eo = '0; e1v = 0; eov = 0; m_ovf = 0;
    end else begin
      bit full, lfull, start, issue;
      logic [PW+3:0] got;
      full  = (dq.size() == DEPTH);
      lfull = (lq.size() == LINES);
      start = !m_busy && lq.size() > 0 && !in_valid;
      issue = start || m_busy;
      got = '0;
      if (issue) got = dq.pop_front();
      eo = e1; eov = e1v; e1 = got; e1v = issue;
      if (start) begin
        int len;
        len = lq.pop_front();
        m_rem = len - 1; m_busy = (len != 1);
      end else if (m_busy) begin
        m_rem--;
        if (m_rem == 0) m_busy = 0;
      end
      if (in_valid) begin
        if (!full && !(in_he && lfull)) begin
          int lv;
          dq.push_back({in_hs, in_he, in_vs, in_ve, in_pix});
          lv = (in_hs ? 0 : m_run) + 1;
          if (in_he) begin lq.push_back(lv); m_run = 0; end
          else m_run = lv;
        end else m_ovf = 1;
      end
    end
  end

  // per-cycle comparison, sampled away from the active edge
  bit in_line = 0;
  always @(negedge clk) begin
    logic [PW+4:0] exp_v, act_v;
    cycles++;
    exp_v = eov ? {1'b1, eo} : '0;
    act_v = {out_valid, out_hs, out_he, out_vs, out_ve, out_pix};
    tests++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL R2/R3/R5 cycle %0d: out act=%h exp=%h", cycles, act_v, exp_v);
    end
    tests++;
    if (overflow !== m_ovf) begin
      fails++;
      $display("FAIL R7/R8 cycle %0d: overflow act=%b exp=%b", cycles, overflow, m_ovf);
    end
    if (rst) in_line = 0;
    else begin
      if (out_valid && out_hs) in_line = 1;
      if (in_line) begin
        tests++;
        if (!out_valid) begin
          fails++;
          $display("FAIL R4 cycle %0d: gap inside line act=0 exp=1", cycles);
        end
      end
      if (out_valid && out_he) in_line = 0;
      if (out_valid) out_cnt++;
    end
  end

  task automatic tick(input bit v, input bit hs, input bit he, input bit vs, input bit ve);
    @(negedge clk);
    in_valid = v; in_hs = v & hs; in_he = v & he; in_vs = v & vs; in_ve = v & ve;
    if (v) begin
      in_pix = pix_seq;
      pix_seq = pix_seq + PW'(16'h0103);
      in_cnt++;
    end else in_pix = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0);
  endtask

  // mode 0: contiguous, 1: every second cycle, 2: bursts of 3 then 2 idle
  task automatic send_line(input int n, input int mode, input bit first, input bit last);
    for (int i = 0; i < n; i++) begin
      tick(1, i == 0, i == n - 1, first && i == 0, last && i == n - 1);
      if (i != n - 1) begin
        if (mode == 1) idle(1);
        else if (mode == 2 && (i % 3) == 2) idle(2);
      end
    end
  endtask

  task automatic check(input bit cond, input string msg);
    tests++;
    if (!cond) begin fails++; $display("FAIL %s", msg); end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; in_valid = 0; in_hs = 0; in_he = 0; in_vs = 0; in_ve = 0;
    idle(2);
    @(negedge clk); rst = 0;
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(2);
    // R1: reset state
    check(out_valid === 0 && out_pix === '0 && {out_hs, out_he, out_vs, out_ve} === 4'b0 && overflow === 0,
          $sformatf("R1 reset state act=%b%h%b exp=0", out_valid, out_pix, overflow));
    @(negedge clk); rst = 0;
    // R2/R3/R9: a frame with mixed input patterns and overlapping replay
    send_line(10, 0, 1, 0); idle(3);
    send_line(10, 1, 0, 0); idle(3);
    send_line(9, 2, 0, 0); idle(1);
    send_line(1, 0, 0, 0); idle(2);
    send_line(7, 1, 0, 1); idle(40);
    check(out_cnt == in_cnt, $sformatf("R2 frame totals act=%0d exp=%0d", out_cnt, in_cnt));
    // R3: a line must not appear before idle follows its end
    send_line(5, 0, 1, 1);
    check(out_valid === 0, $sformatf("R3 early output act=%b exp=0", out_valid));
    idle(30);
    // R6: 64 entries fit when 48 is requested
    send_line(64, 0, 1, 1); idle(80);
    check(overflow === 0, $sformatf("R6 64-entry line act=%b exp=0", overflow));
    check(out_cnt == in_cnt, $sformatf("R6 totals act=%0d exp=%0d", out_cnt, in_cnt));
    // R7: 65th pixel into a full buffer is dropped; flag sticks
    send_line(65, 0, 1, 1); idle(20);
    check(overflow === 1, $sformatf("R7 overflow set act=%b exp=1", overflow));
    idle(20);
    check(overflow === 1, $sformatf("R7 overflow sticky act=%b exp=1", overflow));
    check(out_valid === 0, $sformatf("R7 unterminated line held act=%b exp=0", out_valid));
    do_reset();
    check(overflow === 0, $sformatf("R1 reset clears overflow act=%b exp=0", overflow));
    // R8: three back-to-back lines with two slots waiting
    send_line(2, 0, 1, 0); send_line(2, 0, 0, 0); send_line(2, 0, 0, 1);
    idle(1);
    check(overflow === 1, $sformatf("R8 line slots overflow act=%b exp=1", overflow));
    idle(20);
    do_reset();
    // R9: vector elements after reset, every-second-cycle input
    send_line(6, 1, 1, 1); idle(20);
    idle(5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule